// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address by reading a multi-level radix tree out of memory. A client hands it one request at a time, made of an address and an access kind (load, store or instruction fetch). The walker picks a process identifier from the address quadrant, fetches the matching process table doubleword, and then descends through directory levels until it reaches a leaf. The index width of each level comes from the entry above it. The walker then sets the leaf's reference bit, and also its change bit on stores. It answers with the real address, the page size as a shift and the permissions granted, or with a fault kind and a cause code.

Memory is reached over one doubleword port that carries reads and writes, and only one transaction is outstanding at a time. Requests and responses use valid/ready handshakes. A new request is taken only after the previous response has been consumed. Relocation enables, the current PID and the process table base and size field are static configuration inputs.

Top module: `radix_walker`

## Requirements
- R1: When relocation is off for the access kind (instrReloc for fetches, dataReloc for loads and stores), the response has kind OK (0), rspAddr equal to the request address with bits 63:60 cleared, rspShift 12 and rspPerm 3'b111, and no memory access is made.
- R2: With relocation on, an address whose bits 63:62 are 01 or 10 yields a segment fault without any memory access. A fetch gives kind 1 with rspAddr 0. A load or store gives kind 2 with rspAddr equal to the request address. The cause is 0 in both cases.
- R3: The PID is curPid for quadrant 00 and 0 for quadrant 11. The process table doubleword is read from (prtbBase with bits 63:60 and 11:0 cleared) + PID×16. If PID×16 ≥ 2^(prtbSize+12), the walk faults with cause bit 0 (no translation) and makes no read.
- R4: From the process table doubleword, the initial remaining size is {bits 62:61, bits 7:5} + 31, the root base is the doubleword with bits 63:60 and 7:0 cleared, and the root index width is bits 4:0.
- R5: At each level the index is (address bits 61:0 >> (remaining − width)) masked to width bits. The entry is read from base + index×8, and the remaining size drops by width.
- R6: An index width below 5, or a fifth directory level (more than MAX_LEVELS=4 directory reads), faults with cause bit 1 (bad configuration).
- R7: An entry read with bit 63 clear faults with cause bit 0 (no translation).
- R8: An entry with bits 63 and 62 set is a leaf. rspAddr is (leaf bits 56:12 above the remaining-size mask) OR (address bits below it), and rspShift is the remaining size.
- R9: On success, bit 8 (reference) is set in the leaf, and bit 7 (change) is set only for stores. The leaf is written back to its own address only if this changes it.
- R10: Leaf permission bits: read is granted by bit 2 or bit 1, write by bit 1, execute by bit 0. rspPerm is {exec, write, read}, with write cleared for loads and fetches. If the access lacks its permission, the walk faults with cause bit 2 and makes no write-back.
- R11: Translation faults report kind 3 for fetches (rspAddr 0) and kind 4 for loads and stores (rspAddr = request address). Cause bit 3 (store) is set only for kind-4 faults of stores.
- R12: reqReady is high only while idle. At most one memory transaction is outstanding, and memValid and memAddr are held until memReady. A response stays stable until rspReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instrReloc | input | 1 | Translation enable for fetches |
| dataReloc | input | 1 | Translation enable for loads and stores |
| curPid | input | PID_W | Current process identifier |
| prtbBase | input | 64 | Process table base address |
| prtbSize | input | 5 | Process table size field (2^(n+12) bytes) |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Walker idle and accepting |
| reqAddr | input | 64 | Effective address |
| reqType | input | 2 | 0 load, 1 store, 2 fetch |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response accepted |
| rspKind | output | 3 | 0 OK, 1 fetch segment, 2 data segment, 3 fetch storage, 4 data storage |
| rspCause | output | 4 | Bit 0 no translation, 1 bad config, 2 protection, 3 store |
| rspAddr | output | 64 | Real address, or fault address |
| rspShift | output | 6 | log2 of page size |
| rspPerm | output | 3 | {exec, write, read} |
| memValid | output | 1 | Memory transaction request |
| memReady | input | 1 | Memory accepts transaction |
| memWrite | output | 1 | Transaction is a write |
| memAddr | output | 64 | Doubleword address |
| memWData | output | 64 | Write data |
| memRspValid | input | 1 | Read data valid |
| memRData | input | 64 | Read data |

## Verification
The hardest conditions to reach are the fifth-level depth fault and the write-back paths, because both need a consistent tree in memory. The bench builds a sparse memory holding a four-level tree, a one-gigabyte leaf one level down, and a chain of narrow non-leaf entries that never ends in a leaf. It then sends loads, stores and fetches at the same pages in a fixed order, so that the reference and change bits build up across requests and the write counter shows when a write-back is skipped. memReady toggles every cycle and rspReady is held back, so the hold behaviour of both handshakes comes into play on every walk.

// File: rtl/radix_walker_pkg.sv
package radix_walker_pkg;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [2:0] KIND_OK   = 3'd0;
  localparam logic [2:0] KIND_ISEG = 3'd1;
  localparam logic [2:0] KIND_DSEG = 3'd2;
  localparam logic [2:0] KIND_ISI  = 3'd3;
  localparam logic [2:0] KIND_DSI  = 3'd4;

  // one-hot translation fault causes driven by control
  localparam logic [2:0] CAUSE_NOTRANS = 3'b001;
  localparam logic [2:0] CAUSE_BADCFG  = 3'b010;
  localparam logic [2:0] CAUSE_PROT    = 3'b100;

  localparam logic [63:0] REF_BIT = 64'h0000_0000_0000_0100;
  localparam logic [63:0] CHG_BIT = 64'h0000_0000_0000_0080;
  localparam logic [63:0] RPN_MASK = 64'h01FF_FFFF_FFFF_F000;
  localparam logic [63:0] NLB_MASK = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [63:0] TBL_MASK = 64'h0FFF_FFFF_FFFF_F000;
  localparam logic [63:0] REAL_MASK = 64'h0FFF_FFFF_FFFF_FFFF;
  localparam int          MIN_NLS = 5;

  typedef enum logic [1:0] {SEL_PRTB, SEL_DIR, SEL_PTE} memsel_e;

  typedef struct packed {
    logic     capture;
    logic     loadRoot;
    logic     loadNext;
    logic     loadLeaf;
    logic     finReal;
    logic     finSeg;
    logic     finFault;
    logic     finOk;
    logic [2:0] faultCause;
    memsel_e  memSel;
  } strobe_t;

  typedef struct packed {
    logic realMode;
    logic badQuad;
    logic pidOob;
    logic cfgBad;
    logic entValid;
    logic entLeaf;
    logic protFail;
    logic needWb;
  } flag_t;

endpackage

// File: rtl/radix_walker_dp.sv
module radix_walker_dp
  import radix_walker_pkg::*;
#(
  parameter int PID_W      = 20,
  parameter int MAX_LEVELS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instrReloc,
  input  logic             dataReloc,
  input  logic [PID_W-1:0] curPid,
  input  logic [63:0]      prtbBase,
  input  logic [4:0]       prtbSize,
  input  logic [63:0]      reqAddr,
  input  logic [1:0]       reqType,
  input  logic [63:0]      memRData,
  input  strobe_t          stb,
  output flag_t            flg,
  output logic [63:0]      memAddr,
  output logic [63:0]      memWData,
  output logic [2:0]       rspKind,
  output logic [3:0]       rspCause,
  output logic [63:0]      rspAddr,
  output logic [5:0]       rspShift,
  output logic [2:0]       rspPerm
);

  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  logic [63:0]      eaR;
  logic [1:0]       typeR;
  logic [PID_W-1:0] pidR;
  logic [63:0]      baseR;
  logic [4:0]       nlsR;
  logic [6:0]       remR;
  logic [LVL_W-1:0] lvlR;
  logic [63:0]      pteAddrR;
  logic [63:0]      leafR;

  logic        isFetch, isStore;
  logic [63:0] pidWide, prtbAddr, walkEa;
  logic [6:0]  shiftAmt;
  logic [63:0] idxMask, dirIdx, dirAddr;
  logic [63:0] pageMask, leafRa, newPte;
  logic        permRd, permWr, permEx;

  assign isFetch  = (typeR == ACC_FETCH);
  assign isStore  = (typeR == ACC_STORE);
  assign pidWide  = 64'(pidR);
  assign prtbAddr = (prtbBase & TBL_MASK) + (pidWide << 4);
  assign walkEa   = {2'b00, eaR[61:0]};
  assign shiftAmt = remR - {2'b00, nlsR};
  assign idxMask  = (64'd1 << nlsR) - 64'd1;
  assign dirIdx   = (walkEa >> shiftAmt) & idxMask;
  assign dirAddr  = baseR + (dirIdx << 3);
  assign pageMask = (64'd1 << remR) - 64'd1;
  assign leafRa   = (leafR & RPN_MASK & ~pageMask) | (walkEa & pageMask);
  assign newPte   = leafR | REF_BIT | (isStore ? CHG_BIT : 64'd0);
  assign permRd   = leafR[2] | leafR[1];
  assign permWr   = leafR[1];
  assign permEx   = leafR[0];

  always_comb begin
    flg.realMode = isFetch ? !instrReloc : !dataReloc;
    flg.badQuad  = (eaR[63:62] == 2'b01) || (eaR[63:62] == 2'b10);
    flg.pidOob   = (pidWide >> ({1'b0, prtbSize} + 6'd8)) != 64'd0;
    flg.cfgBad   = (nlsR < 5'(MIN_NLS)) || ({2'b00, nlsR} > remR) ||
                   (lvlR == LVL_W'(MAX_LEVELS));
    flg.entValid = memRData[63];
    flg.entLeaf  = memRData[62];
    case (typeR)
      ACC_STORE: flg.protFail = !permWr;
      ACC_FETCH: flg.protFail = !permEx;
      default:   flg.protFail = !permRd;
    endcase
    flg.needWb   = (newPte != leafR);
  end

  always_comb begin
    case (stb.memSel)
      SEL_DIR: memAddr = dirAddr;
      SEL_PTE: memAddr = pteAddrR;
      default: memAddr = prtbAddr;
    endcase
  end
  assign memWData = newPte;

  // walk state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eaR      <= '0;
      typeR    <= '0;
      pidR     <= '0;
      baseR    <= '0;
      nlsR     <= '0;
      remR     <= '0;
      lvlR     <= '0;
      pteAddrR <= '0;
      leafR    <= '0;
    end else begin
      if (stb.capture) begin
        eaR   <= reqAddr;
        typeR <= reqType;
        pidR  <= (reqAddr[63:62] == 2'b11) ? '0 : curPid;
      end
      if (stb.loadRoot) begin
        remR  <= 7'({memRData[62:61], memRData[7:5]}) + 7'd31;
        baseR <= memRData & NLB_MASK;
        nlsR  <= memRData[4:0];
        lvlR  <= '0;
      end
      if (stb.loadNext) begin
        remR  <= shiftAmt;
        baseR <= memRData & NLB_MASK;
        nlsR  <= memRData[4:0];
        lvlR  <= lvlR + 1'b1;
      end
      if (stb.loadLeaf) begin
        remR     <= shiftAmt;
        leafR    <= memRData;
        pteAddrR <= dirAddr;
      end
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspKind  <= KIND_OK;
      rspCause <= '0;
      rspAddr  <= '0;
      rspShift <= '0;
      rspPerm  <= '0;
    end else if (stb.finReal) begin
      rspKind  <= KIND_OK;
      rspCause <= '0;
      rspAddr  <= eaR & REAL_MASK;
      rspShift <= 6'd12;
      rspPerm  <= 3'b111;
    end else if (stb.finSeg) begin
      rspKind  <= isFetch ? KIND_ISEG : KIND_DSEG;
      rspCause <= '0;
      rspAddr  <= isFetch ? 64'd0 : eaR;
      rspShift <= '0;
      rspPerm  <= '0;
    end else if (stb.finFault) begin
      rspKind  <= isFetch ? KIND_ISI : KIND_DSI;
      rspCause <= {isStore, stb.faultCause};
      rspAddr  <= isFetch ? 64'd0 : eaR;
      rspShift <= '0;
      rspPerm  <= '0;
    end else if (stb.finOk) begin
      rspKind  <= KIND_OK;
      rspCause <= '0;
      rspAddr  <= leafRa;
      rspShift <= remR[5:0];
      rspPerm  <= {permEx, permWr & isStore, permRd};
    end
  end

endmodule

// File: rtl/radix_walker_ctrl.sv
module radix_walker_ctrl
  import radix_walker_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  output logic    reqReady,
  output logic    rspValid,
  input  logic    rspReady,
  output logic    memValid,
  output logic    memWrite,
  input  logic    memReady,
  input  logic    memRspValid,
  input  flag_t   flg,
  output strobe_t stb
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLASSIFY, ST_PRTB_REQ, ST_PRTB_WAIT, ST_CHECK,
    ST_DIR_REQ, ST_DIR_WAIT, ST_LEAF, ST_WB_REQ, ST_RESP
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    stb.memSel = SEL_PRTB;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capture = 1'b1;
          nextState   = ST_CLASSIFY;
        end
      end
      ST_CLASSIFY: begin
        if (flg.realMode) begin
          stb.finReal = 1'b1;
          nextState   = ST_RESP;
        end else if (flg.badQuad) begin
          stb.finSeg = 1'b1;
          nextState  = ST_RESP;
        end else if (flg.pidOob) begin
          stb.finFault   = 1'b1;
          stb.faultCause = CAUSE_NOTRANS;
          nextState      = ST_RESP;
        end else begin
          nextState = ST_PRTB_REQ;
        end
      end
      ST_PRTB_REQ: begin
        memValid   = 1'b1;
        stb.memSel = SEL_PRTB;
        if (memReady) nextState = ST_PRTB_WAIT;
      end
      ST_PRTB_WAIT: begin
        if (memRspValid) begin
          stb.loadRoot = 1'b1;
          nextState    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (flg.cfgBad) begin
          stb.finFault   = 1'b1;
          stb.faultCause = CAUSE_BADCFG;
          nextState      = ST_RESP;
        end else begin
          nextState = ST_DIR_REQ;
        end
      end
      ST_DIR_REQ: begin
        memValid   = 1'b1;
        stb.memSel = SEL_DIR;
        if (memReady) nextState = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (memRspValid) begin
          if (!flg.entValid) begin
            stb.finFault   = 1'b1;
            stb.faultCause = CAUSE_NOTRANS;
            nextState      = ST_RESP;
          end else if (flg.entLeaf) begin
            stb.loadLeaf = 1'b1;
            nextState    = ST_LEAF;
          end else begin
            stb.loadNext = 1'b1;
            nextState    = ST_CHECK;
          end
        end
      end
      ST_LEAF: begin
        if (flg.protFail) begin
          stb.finFault   = 1'b1;
          stb.faultCause = CAUSE_PROT;
          nextState      = ST_RESP;
        end else begin
          stb.finOk = 1'b1;
          nextState = flg.needWb ? ST_WB_REQ : ST_RESP;
        end
      end
      ST_WB_REQ: begin
        memValid   = 1'b1;
        memWrite   = 1'b1;
        stb.memSel = SEL_PTE;
        if (memReady) nextState = ST_RESP;
      end
      ST_RESP: begin
        rspValid = 1'b1;
        if (rspReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walker_pkg::*;
#(
  parameter int PID_W      = 20,
  parameter int MAX_LEVELS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instrReloc,
  input  logic             dataReloc,
  input  logic [PID_W-1:0] curPid,
  input  logic [63:0]      prtbBase,
  input  logic [4:0]       prtbSize,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [63:0]      reqAddr,
  input  logic [1:0]       reqType,
  output logic             rspValid,
  input  logic             rspReady,
  output logic [2:0]       rspKind,
  output logic [3:0]       rspCause,
  output logic [63:0]      rspAddr,
  output logic [5:0]       rspShift,
  output logic [2:0]       rspPerm,
  output logic             memValid,
  input  logic             memReady,
  output logic             memWrite,
  output logic [63:0]      memAddr,
  output logic [63:0]      memWData,
  input  logic             memRspValid,
  input  logic [63:0]      memRData
);

  strobe_t stb;
  flag_t   flg;

  radix_walker_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .memValid(memValid), .memWrite(memWrite),
    .memReady(memReady), .memRspValid(memRspValid),
    .flg(flg), .stb(stb)
  );

  radix_walker_dp #(.PID_W(PID_W), .MAX_LEVELS(MAX_LEVELS)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .instrReloc(instrReloc), .dataReloc(dataReloc),
    .curPid(curPid), .prtbBase(prtbBase), .prtbSize(prtbSize),
    .reqAddr(reqAddr), .reqType(reqType), .memRData(memRData),
    .stb(stb), .flg(flg),
    .memAddr(memAddr), .memWData(memWData),
    .rspKind(rspKind), .rspCause(rspCause), .rspAddr(rspAddr),
    .rspShift(rspShift), .rspPerm(rspPerm)
  );

endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reqReady,
  input logic        rspValid,
  input logic        rspReady,
  input logic [2:0]  rspKind,
  input logic [3:0]  rspCause,
  input logic [63:0] rspAddr,
  input logic        memValid,
  input logic        memReady,
  input logic        memWrite,
  input logic [63:0] memAddr,
  input logic [63:0] memWData
);

  AST_RSP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> !reqReady); // R12

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspAddr) &&
                                 $stable(rspKind) && $stable(rspCause))); // R12

  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite))); // R12

  AST_MEM_IDLE_WHEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> !memValid); // R12

  AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && memWrite) |-> memWData[8]); // R9

  AST_DW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    memValid |-> (memAddr[2:0] == 3'b000)); // R5

  AST_IFETCH_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && (rspKind == 3'd1 || rspKind == 3'd3)) |-> (rspAddr == 64'd0)); // R11

  AST_IFETCH_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspKind == 3'd3) |-> !rspCause[3]); // R11

endmodule

bind radix_walker radix_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reqReady(reqReady), .rspValid(rspValid),
  .rspReady(rspReady), .rspKind(rspKind), .rspCause(rspCause),
  .rspAddr(rspAddr), .memValid(memValid), .memReady(memReady),
  .memWrite(memWrite), .memAddr(memAddr), .memWData(memWData)
);

// File: tb/radix_walker_test.sv
module radix_walker_test;

  localparam int PID_W = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             instrReloc = 1'b0;
  logic             dataReloc = 1'b0;
  logic [PID_W-1:0] curPid = '0;
  logic [63:0]      prtbBase = 64'h1_0000;
  logic [4:0]       prtbSize = 5'd0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [63:0]      reqAddr = '0;
  logic [1:0]       reqType = '0;
  logic             rspValid;
  logic             rspReady = 1'b0;
  logic [2:0]       rspKind;
  logic [3:0]       rspCause;
  logic [63:0]      rspAddr;
  logic [5:0]       rspShift;
  logic [2:0]       rspPerm;
  logic             memValid;
  logic             memReady = 1'b0;
  logic             memWrite;
  logic [63:0]      memAddr;
  logic [63:0]      memWData;
  logic             memRspValid = 1'b0;
  logic [63:0]      memRData = '0;

  always #4 clk = ~clk;

  radix_walker #(.PID_W(PID_W), .MAX_LEVELS(4)) uut (.*);

  int checks = 0;
  int fails  = 0;
  int rdCnt  = 0;
  int wrCnt  = 0;

  typedef struct {
    logic [2:0]  kind;
    logic [3:0]  cause;
    logic [63:0] addr;
    logic [5:0]  shift;
    logic [2:0]  perm;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [63:0] mem [logic [63:0]];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory model: toggling ready, read data one cycle after acceptance
  initial begin
    logic        pend;
    logic [63:0] pendAddr;
    pend = 1'b0;
    pendAddr = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        memRspValid = 1'b1;
        memRData = mem.exists(pendAddr) ? mem[pendAddr] : 64'd0;
        pend = 1'b0;
      end else begin
        memRspValid = 1'b0;
      end
      memReady = ~memReady;
      if (rst_n && memValid && memReady) begin
        if (memWrite) begin
          mem[memAddr] = memWData;
          wrCnt++;
        end else begin
          pend = 1'b1;
          pendAddr = memAddr;
          rdCnt++;
        end
      end
    end
  end

  // scoreboard monitor: holds rspReady low two cycles, then compares
  initial begin
    int hold;
    hold = 0;
    forever begin
      @(negedge clk);
      rspReady = 1'b0;
      if (rst_n && rspValid) begin
        hold++;
        if (hold == 3) begin
          hold = 0;
          rspReady = 1'b1;
          if (sb.size() == 0) begin
            check(1'b0, "R12", "unexpected response", 64'(rspKind), 64'd0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(rspKind == e.kind, e.tag, "kind", 64'(rspKind), 64'(e.kind));
            check(rspCause == e.cause, e.tag, "cause", 64'(rspCause), 64'(e.cause));
            check(rspAddr == e.addr, e.tag, "addr", rspAddr, e.addr);
            if (e.kind == 3'd0) begin
              check(rspShift == e.shift, e.tag, "shift", 64'(rspShift), 64'(e.shift));
              check(rspPerm == e.perm, e.tag, "perm", 64'(rspPerm), 64'(e.perm));
            end
          end
        end
      end
    end
  end

  task automatic issue(input logic [63:0] ea, input logic [1:0] ty,
                       input logic [2:0] k, input logic [3:0] c,
                       input logic [63:0] a, input logic [5:0] sh,
                       input logic [2:0] pm, input string tag);
    exp_t e;
    e.kind = k; e.cause = c; e.addr = a; e.shift = sh; e.perm = pm; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr  = ea;
    reqType  = ty;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R12", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    int r0, w0;
    // tree for PID 5: 4 levels of widths 13,9,9,9
    mem[64'h1_0050] = 64'h4000_0000_0002_00AD;
    mem[64'h2_0008] = 64'h8000_0000_0003_0009;
    mem[64'h3_0010] = 64'h8000_0000_0004_0009;
    mem[64'h4_0018] = 64'h8000_0000_0005_0009;
    mem[64'h5_0020] = 64'hC000_0000_ABCD_E006;
    mem[64'h3_0028] = 64'hC000_0040_0000_0005;
    // PID 0: width 4 root
    mem[64'h1_0000] = 64'h4000_0000_0006_00A4;
    // PID 6: endless chain of width-5 directories
    mem[64'h1_0060] = 64'h4000_0000_0007_00A5;
    mem[64'h7_0000] = 64'h8000_0000_0007_1005;
    mem[64'h7_1000] = 64'h8000_0000_0007_2005;
    mem[64'h7_2000] = 64'h8000_0000_0007_3005;
    mem[64'h7_3000] = 64'h8000_0000_0007_4005;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(reqReady == 1'b1, "R12", "reqReady after reset", 64'(reqReady), 64'd1);
    check(rspValid == 1'b0, "R12", "rspValid after reset", 64'(rspValid), 64'd0);
    check(memValid == 1'b0, "R12", "memValid after reset", 64'(memValid), 64'd0);

    // R1: real mode load and fetch
    instrReloc = 1'b1; dataReloc = 1'b0;
    r0 = rdCnt;
    issue(64'hF234_5678_9ABC_DEF0, 2'd0, 3'd0, 4'd0, 64'h0234_5678_9ABC_DEF0, 6'd12, 3'b111, "R1");
    check(rdCnt == r0, "R1", "reads in real mode", 64'(rdCnt - r0), 64'd0);
    // R2: fetch still translated, quadrant 1
    issue(64'h4000_0000_0000_1000, 2'd2, 3'd1, 4'd0, 64'd0, 6'd0, 3'd0, "R2");
    instrReloc = 1'b0;
    issue(64'hFFFF_FFFF_FFFF_F000, 2'd2, 3'd0, 4'd0, 64'h0FFF_FFFF_FFFF_F000, 6'd12, 3'b111, "R1");

    instrReloc = 1'b1; dataReloc = 1'b1;
    r0 = rdCnt;
    issue(64'h8000_0000_0000_2000, 2'd0, 3'd2, 4'd0, 64'h8000_0000_0000_2000, 6'd0, 3'd0, "R2");
    check(rdCnt == r0, "R2", "reads on segment fault", 64'(rdCnt - r0), 64'd0);

    // R3 R4 R5 R8 R9 R10: four-level load
    curPid = 20'd5;
    r0 = rdCnt; w0 = wrCnt;
    issue(64'h0000_0080_8060_4123, 2'd0, 3'd0, 4'd0, 64'h0000_0000_ABCD_E123, 6'd12, 3'b001, "R8");
    check(rdCnt - r0 == 5, "R5", "reads in 4-level walk", 64'(rdCnt - r0), 64'd5);
    check(mem[64'h5_0020] == 64'hC000_0000_ABCD_E106, "R9", "ref bit written",
          mem[64'h5_0020], 64'hC000_0000_ABCD_E106);
    check(wrCnt - w0 == 1, "R9", "write-back count", 64'(wrCnt - w0), 64'd1);
    // R9 store sets change
    issue(64'h0000_0080_8060_4123, 2'd1, 3'd0, 4'd0, 64'h0000_0000_ABCD_E123, 6'd12, 3'b011, "R10");
    check(mem[64'h5_0020] == 64'hC000_0000_ABCD_E186, "R9", "change bit written",
          mem[64'h5_0020], 64'hC000_0000_ABCD_E186);
    // R9 unchanged leaf not written
    w0 = wrCnt;
    issue(64'h0000_0080_8060_4123, 2'd0, 3'd0, 4'd0, 64'h0000_0000_ABCD_E123, 6'd12, 3'b001, "R9");
    check(wrCnt == w0, "R9", "no write when unchanged", 64'(wrCnt - w0), 64'd0);
    // R10 R11 fetch without exec
    issue(64'h0000_0080_8060_4123, 2'd2, 3'd3, 4'b0100, 64'd0, 6'd0, 3'd0, "R10");

    // R8: 1 GiB leaf one level down, fetch allowed
    issue(64'h0000_0081_5234_5678, 2'd2, 3'd0, 4'd0, 64'h0000_0040_1234_5678, 6'd30, 3'b101, "R8");
    check(mem[64'h3_0028] == 64'hC000_0040_0000_0105, "R9", "ref bit on big leaf",
          mem[64'h3_0028], 64'hC000_0040_0000_0105);
    // R10 R11 store to read-only page
    w0 = wrCnt;
    issue(64'h0000_0081_5234_5678, 2'd1, 3'd4, 4'b1100, 64'h0000_0081_5234_5678, 6'd0, 3'd0, "R11");
    check(wrCnt == w0, "R10", "no write-back on protection fault", 64'(wrCnt - w0), 64'd0);

    // R7: invalid entry, load then store
    issue(64'h0000_0100_0000_0000, 2'd0, 3'd4, 4'b0001, 64'h0000_0100_0000_0000, 6'd0, 3'd0, "R7");
    issue(64'h0000_0100_0000_0000, 2'd1, 3'd4, 4'b1001, 64'h0000_0100_0000_0000, 6'd0, 3'd0, "R11");

    // R3 R6: quadrant 3 forces PID 0, whose root width is 4
    issue(64'hC000_0000_0000_1000, 2'd0, 3'd4, 4'b0010, 64'hC000_0000_0000_1000, 6'd0, 3'd0, "R6");

    // R6: depth limit
    curPid = 20'd6;
    r0 = rdCnt;
    issue(64'd0, 2'd0, 3'd4, 4'b0010, 64'd0, 6'd0, 3'd0, "R6");
    check(rdCnt - r0 == 5, "R6", "reads before depth fault", 64'(rdCnt - r0), 64'd5);

    // R3: process table bound
    curPid = 20'd256;
    r0 = rdCnt;
    issue(64'h0000_0000_0000_3000, 2'd0, 3'd4, 4'b0001, 64'h0000_0000_0000_3000, 6'd0, 3'd0, "R3");
    check(rdCnt == r0, "R3", "no read when PID out of range", 64'(rdCnt - r0), 64'd0);
    curPid = 20'd255;
    r0 = rdCnt;
    issue(64'h0000_0000_0000_3000, 2'd0, 3'd4, 4'b0010, 64'h0000_0000_0000_3000, 6'd0, 3'd0, "R3");
    check(rdCnt - r0 == 1, "R3", "last in-range PID read", 64'(rdCnt - r0), 64'd1);
    curPid = 20'd256; prtbSize = 5'd1;
    issue(64'h0000_0000_0000_3000, 2'd0, 3'd4, 4'b0010, 64'h0000_0000_0000_3000, 6'd0, 3'd0, "R3");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule